// File: doc/BRIEF.md
# Asynchronous Match-Table Control Port

This block is the host-facing register port of a small content-addressable match table. A host reaches eight 16-bit registers through a 3-bit address, a shared 16-bit bidirectional data bus, and a four-phase handshake. The host raises a select line, the block answers with an acknowledge, the host drops select, and the block drops acknowledge. Every host input is asynchronous to the block clock, so all of them are passed through a two-stage synchronizer before they are used.

The port holds a status word, a fault word, an almost-full threshold, a command register and four general registers. The status word carries a completion bit and a queue-empty bit. A write to the command register starts a modelled operation: it clears the completion bit, and a fixed delay later it sets the bit again. A synchronous match-request input stands for the table's match port, which always takes priority. While that input is high, no host access is started, and a pending completion is held back.

Top module: `cam_ctrl_port`

## Requirements
- R1: After reset, address 0 (status) reads 0x001C, address 1 (fault) reads 0xFFFF, address 2 (threshold) reads 0x3FFF, and addresses 3 to 7 read 0x0000. After reset `host_ack` is low and `op_done` is low.
- R2: Select high with `host_we_n` high starts a read. Once `host_ack` rises, the block drives the addressed register's value on `host_data` for as long as `host_ack` stays high.
- R3: Select high with `host_we_n` low stores the bus value into address 2, 3, 4, 5, 6 or 7, then raises `host_ack`. A later read returns the stored value.
- R4: `host_ack` stays high until the block has seen select low through its synchronizer. It is therefore still high on the first clock after select falls, and it drops after that.
- R5: Writes to address 0 and address 1 are acknowledged but change nothing: both addresses keep reading their prior values.
- R6: While `match_req` is high, no new host access is started and `host_ack` does not rise. The access proceeds once `match_req` is low.
- R7: A write to address 3 clears the completion flag, which is bit 10 of address 0 and is also output as `op_done`. The written command code reads back from address 3.
- R8: After a write to address 3, the completion flag is set on the first clock that is at least CMD_CYCLES+1 cycles after the write and sees `match_req` low. While `match_req` is high, the flag stays clear.
- R9: Bit 4 of address 0 (queue empty) always reads 1, and bits 2 and 3 (buffered-entry mode) always read 1. Bit 10 always equals `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 1 | Host select, asynchronous, active high |
| host_we_n | input | 1 | Low for a write, high for a read |
| host_addr | input | 3 | Register address |
| host_data | inout | 16 | Bidirectional data bus, driven by the block only during a read while acknowledge is high |
| host_ack | output | 1 | Transfer acknowledge |
| match_req | input | 1 | Synchronous match-port request; has priority over the host |
| op_done | output | 1 | Last-operation-complete flag |

## Verification
Two events can meet in the same cycle. A host access can arrive while the match port is busy, and a command's completion deadline can expire while the match port is busy. The bench provokes the first by raising `match_req` before select, and the second by holding `match_req` across the completion deadline. It judges both at the ports: `host_ack` must stay low, and `op_done` must stay clear, for as long as the request is held. When the request is released, the access completes with the correct data and the flag rises within a few cycles. Randomly chosen reads and writes to the ordinary registers are checked against a bench-side register model.

// File: rtl/cam_ctrl_port.sv
module cam_ctrl_port #(
  parameter int CMD_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_we_n,
  input  logic [2:0] host_addr,
  inout  wire [15:0] host_data,
  output logic       host_ack,
  input  logic       match_req,
  output logic       op_done
);
  localparam int SW = 21;
  localparam int CW = $clog2(CMD_CYCLES + 1);

  logic [SW-1:0] sy1, sy2;
  logic          rd_q, busy;
  logic [15:0]   rdata, thresh, cmd;
  logic [15:0]   gp [4];
  logic [CW-1:0] cnt;
  logic [15:0]   rmux;

  wire        sel_s  = sy2[20];
  wire        we_n_s = sy2[19];
  wire [2:0]  addr_s = sy2[18:16];
  wire [15:0] wdat_s = sy2[15:0];
  wire        go     = sel_s && !host_ack && !match_req;

  assign host_data = (host_ack && rd_q) ? rdata : 'z;

  always_comb begin
    case (addr_s)
      3'd0:    rmux = {5'b0, op_done, 10'h01C};
      3'd1:    rmux = 16'hFFFF;
      3'd2:    rmux = thresh;
      3'd3:    rmux = cmd;
      default: rmux = gp[addr_s[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {host_sel, host_we_n, host_addr, host_data};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack <= 1'b0;
      rd_q     <= 1'b0;
      rdata    <= '0;
      thresh   <= 16'h3FFF;
      cmd      <= '0;
      for (int i = 0; i < 4; i++) gp[i] <= '0;
      op_done  <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else begin
      if (busy) begin
        if (cnt != 0) cnt <= cnt - 1'b1;
        else if (!match_req) begin
          op_done <= 1'b1;
          busy    <= 1'b0;
        end
      end
      if (go) begin
        host_ack <= 1'b1;
        rd_q     <= we_n_s;
        if (we_n_s) rdata <= rmux;
        else begin
          case (addr_s)
            3'd0, 3'd1: ;
            3'd2: thresh <= wdat_s;
            3'd3: begin
              cmd     <= wdat_s;
              op_done <= 1'b0;
              busy    <= 1'b1;
              cnt     <= CW'(CMD_CYCLES);
            end
            default: gp[addr_s[1:0]] <= wdat_s;
          endcase
        end
      end else if (host_ack && !sel_s) begin
        host_ack <= 1'b0;
      end
    end
  end
endmodule

module cam_ctrl_port_chk (
  input logic clk,
  input logic rst_n,
  input logic host_sel,
  input logic host_ack,
  input logic match_req,
  input logic op_done
);
  p_match_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> !$past(match_req));
  p_ack_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> $past(host_sel));
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack) |-> !$past(host_sel));
  p_done_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_done) |-> !$past(match_req));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_done) |-> $rose(host_ack));
endmodule

bind cam_ctrl_port cam_ctrl_port_chk u_chk (.*);

// File: tb/cam_ctrl_port_tb.sv
module cam_ctrl_port_tb;
  localparam int CLK_P = 10;
  localparam int CMDC  = 40;

  logic clk = 0, rst_n = 0;
  logic sel = 0, we_n = 1, mreq = 0;
  logic [2:0] addr = 0;
  logic drv = 0;
  logic [15:0] dval = 0;
  wire  [15:0] bus;
  wire  ack, done;
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] model [8];
  logic done_model = 0;

  assign bus = drv ? dval : 'z;
  always #(CLK_P/2) clk = ~clk;

  cam_ctrl_port #(.CMD_CYCLES(CMDC)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_we_n(we_n),
    .host_addr(addr), .host_data(bus), .host_ack(ack),
    .match_req(mreq), .op_done(done));

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    if (a == 0) return {5'b0, done_model, 10'h01C};
    if (a == 1) return 16'hFFFF;
    return model[a];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_ack(input logic lvl);
    for (int i = 0; i < 300 && ack !== lvl; i++) @(negedge clk);
  endtask

  task automatic finish_xfer(input logic rd, output logic [15:0] d);
    wait_ack(1);
    d = bus;
    sel = 0;
    @(negedge clk);
    if (rd) chk("R4 ack held after sel drop", {15'b0, ack}, 16'h1);
    wait_ack(0);
    drv = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    @(negedge clk);
    addr = a; we_n = 0; dval = d; drv = 1; sel = 1;
    finish_xfer(0, dummy);
    if (a >= 2) model[a] = d;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; we_n = 1; drv = 0; sel = 1;
    finish_xfer(1, d);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog got=%0d exp=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = 0;
    model[2] = 16'h3FFF;
    repeat (3) @(negedge clk);
    chk("R1 ack low in reset", {15'b0, ack}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 op_done low", {15'b0, done}, 0);
    for (int a = 0; a < 8; a++) begin
      do_read(3'(a), r);
      chk($sformatf("R1 reset value addr %0d", a), r, exp_read(3'(a)));
    end
    do_read(0, r);
    chk("R9 status mode/empty bits", r & 16'h001C, 16'h001C);
    do_write(0, 16'h0000);
    do_write(1, 16'h1234);
    do_read(0, r); chk("R5 status write ignored", r, exp_read(0));
    do_read(1, r); chk("R5 fault write ignored", r, 16'hFFFF);
    do_write(2, 16'hBEEF);
    do_read(2, r); chk("R3 threshold write", r, 16'hBEEF);

    for (int n = 0; n < 60; n++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      if (a == 3) a = 4;
      if ($urandom_range(0, 1) == 0 && a >= 2) do_write(a, 16'($urandom));
      else begin
        do_read(a, r);
        chk($sformatf("R2 random read addr %0d", a), r, exp_read(a));
      end
    end

    do_write(3, 16'h00A5);
    chk("R7 op_done cleared", {15'b0, done}, 0);
    do_read(3, r); chk("R7 command readback", r, 16'h00A5);
    do_read(0, r); chk("R7 bit10 clear", r, 16'h001C);
    repeat (CMDC + 10) @(negedge clk);
    chk("R8 op_done set after delay", {15'b0, done}, 1);
    done_model = 1;
    do_read(0, r); chk("R9 bit10 mirrors op_done", r, 16'h041C);

    do_write(3, 16'h0042);
    mreq = 1;
    repeat (CMDC + 40) @(negedge clk);
    chk("R8 done held while match busy", {15'b0, done}, 0);
    mreq = 0;
    repeat (3) @(negedge clk);
    chk("R8 done after match release", {15'b0, done}, 1);

    mreq = 1;
    @(negedge clk);
    addr = 2; we_n = 1; drv = 0; sel = 1;
    repeat (20) @(negedge clk);
    chk("R6 no ack while match busy", {15'b0, ack}, 0);
    mreq = 0;
    finish_xfer(1, r);
    chk("R6 stalled read data", r, exp_read(2));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule